// File: doc/BRIEF.md
# Port Pin Interrupt and Keyboard Unit

This block watches an eight-bit general-purpose port and turns pin activity into interrupt requests for a separate interrupt controller. The four low pins can each raise their own request. Each request is either level-sensitive or edge-sensitive, and a per-pin polarity bit sets which level or which edge is active. All eight pins can also feed one combined keyboard interrupt, active low at the pin. A wake output tells the system to leave a low-power state.

Software sets the unit up through a small byte-wide register port. It holds direction, polarity, request enable, keyboard enable and edge-mode bits. It also has a flag window: reading it returns the latched edge events, and writing a 1 to a bit clears that event. Every pin passes through a two-flop synchronizer before any detection. The keyboard path uses only its own enable bits and the pin direction. It has no clear of its own and stays asserted until the keys are released.

Top module: `portirq_top`

## Requirements
- R1: After reset, all configuration registers read 0x00, the edge flags are clear, and `irq_o`, `kbd_irq_o` and `wake_o` are low.
- R2: Register address 2 holds the request enables. Bits 3..0 gate pins 3..0 (1 = the request reaches `irq_o`, 0 = it is blocked). Bits 7..4 cannot be stored and read back as 0.
- R3: Register address 3 holds the keyboard enables, one bit per pin over all eight bits, and reads back what was written. The other addresses are: 0 direction, 1 polarity, 4 edge mode, 5 edge flags.
- R4: `kbd_irq_o` is high while any pin that has its keyboard enable bit set and is an input reads low after synchronization.
- R5: Polarity, request-enable and edge-mode settings have no effect on `kbd_irq_o`.
- R6: No register write clears `kbd_irq_o`. It falls only when every enabled keyboard pin reads high again.
- R7: In level mode (edge bit 0), `irq_o[i]` is high while the synchronized pin equals the active level. Polarity 0 selects high as active and polarity 1 selects low. The pin must also be an input and enabled. Nothing is latched.
- R8: In edge mode (edge bit 1), a rising edge with polarity 0, or a falling edge with polarity 1, sets a sticky flag for that pin one cycle after the edge is seen. `irq_o[i]` is the flag gated by the enable. The flag window (address 5) reads the flags.
- R9: Writing 1 to a bit of address 5 clears that flag, and writing 0 leaves it unchanged. If an edge and a clear arrive in the same cycle, the edge wins.
- R10: `wake_o` is high when the keyboard interrupt or any level-mode request is high. An edge-mode request never raises it.
- R11: A pin whose direction bit is 1 (output) raises neither a request nor a keyboard interrupt.
- R12: A pin change reaches the level and keyboard outputs after exactly two clock edges, through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Raw port pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| irq_o | output | 4 | Per-pin interrupt requests, pins 3..0 |
| kbd_irq_o | output | 1 | Combined keyboard interrupt |
| wake_o | output | 1 | Wake request |

## Verification
The hardest case to reach is an edge flag that is held while its pin goes on moving, and that is then cleared only by software while the enable gating is changed around it. The stimulus puts a pin in edge mode and first drives the opposite edge, so the flag must stay clear. It then drives the selected edge, drives the other edge again to show the flag holds, writes a zero-mask clear and then a one-mask clear, and switches the enable off and on. Between these steps it reads the flag window. The keyboard path is kept low through changes of polarity, enable, edge mode and a flag clear. This shows that only the pins release it.

// File: rtl/portirq_pkg.sv
package portirq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] A_POL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_KBEN = 3'd3;
  localparam logic [ADDR_W-1:0] A_EDGE = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd5;

  // active level after polarity: pol 0 -> high active, pol 1 -> low active
  function automatic logic f_active(input logic lvl, input logic pol);
    return lvl ^ pol;
  endfunction

  // transition into the active level between two samples
  function automatic logic f_edge(input logic prev, input logic cur, input logic pol);
    return !f_active(prev, pol) && f_active(cur, pol);
  endfunction
endpackage

// File: rtl/portirq_sync.sv
module portirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  // idle level of the port is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      q_o    <= '1;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/portirq_regs.sv
module portirq_regs
  import portirq_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int NREQ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  input  logic [NREQ-1:0]   flags,
  output logic [NPIN-1:0]   rdata,
  output logic [NPIN-1:0]   dir,
  output logic [NPIN-1:0]   kben,
  output logic [NREQ-1:0]   pol,
  output logic [NREQ-1:0]   ien,
  output logic [NREQ-1:0]   edge_sel,
  output logic [NREQ-1:0]   flag_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir      <= '0;
      kben     <= '0;
      pol      <= '0;
      ien      <= '0;
      edge_sel <= '0;
    end else if (wr) begin
      case (addr)
        A_DIR:   dir      <= wdata;
        A_KBEN:  kben     <= wdata;
        A_POL:   pol      <= wdata[NREQ-1:0];
        A_IEN:   ien      <= wdata[NREQ-1:0];
        A_EDGE:  edge_sel <= wdata[NREQ-1:0];
        default: ;
      endcase
    end
  end

  assign flag_clr = (wr && addr == A_FLAG) ? wdata[NREQ-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIR:   rdata = dir;
      A_KBEN:  rdata = kben;
      A_POL:   rdata[NREQ-1:0] = pol;
      A_IEN:   rdata[NREQ-1:0] = ien;
      A_EDGE:  rdata[NREQ-1:0] = edge_sel;
      A_FLAG:  rdata[NREQ-1:0] = flags;
      default: rdata = '0;
    endcase
  end

  // R2: upper enable bits never come back
  p_ien_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_IEN) |-> (rdata[NPIN-1:NREQ] == '0));
endmodule

// File: rtl/portirq_req_det.sv
module portirq_req_det
  import portirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic is_out,
  input  logic pol,
  input  logic en,
  input  logic edge_mode,
  input  logic clr,
  output logic irq,
  output logic lvl_req,
  output logic flag
);
  logic prev;
  logic edge_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= pin_s;
  end

  assign edge_evt = edge_mode && !is_out && f_edge(prev, pin_s, pol);

  // set has priority over a software clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (edge_evt) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  assign lvl_req = !edge_mode && !is_out && en && f_active(pin_s, pol);
  assign irq     = lvl_req || (edge_mode && en && flag);

  // R8: a flag only appears after a detected edge
  p_flag_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(edge_evt));
  // R9: a flag only drops after a software clear
  p_flag_needs_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr));
endmodule

// File: rtl/portirq_kbd.sv
module portirq_kbd #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_s,
  input  logic [NPIN-1:0] kben,
  input  logic [NPIN-1:0] dir,
  output logic            kbd
);
  logic [NPIN-1:0] key_down;

  assign key_down = kben & ~dir & ~pin_s;
  assign kbd      = |key_down;

  // R6: release needs a pin or configuration change, never a clear strobe
  p_kbd_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kbd) |-> (pin_s != $past(pin_s)) || (kben != $past(kben)) || (dir != $past(dir)));
endmodule

// File: rtl/portirq_top.sv
module portirq_top
  import portirq_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int NREQ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  output logic [NREQ-1:0]   irq_o,
  output logic              kbd_irq_o,
  output logic              wake_o
);
  logic [NPIN-1:0] pin_s, dir, kben;
  logic [NREQ-1:0] pol, ien, edge_sel, flag_clr, flags, lvl_req;

  portirq_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s));

  portirq_regs #(.NPIN(NPIN), .NREQ(NREQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .flags(flags), .rdata(bus_rdata), .dir(dir), .kben(kben), .pol(pol),
    .ien(ien), .edge_sel(edge_sel), .flag_clr(flag_clr));

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    portirq_req_det u_det (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]), .is_out(dir[i]), .pol(pol[i]),
      .en(ien[i]), .edge_mode(edge_sel[i]), .clr(flag_clr[i]),
      .irq(irq_o[i]), .lvl_req(lvl_req[i]), .flag(flags[i]));
  end

  portirq_kbd #(.NPIN(NPIN)) u_kbd (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .kben(kben), .dir(dir), .kbd(kbd_irq_o));

  assign wake_o = kbd_irq_o || (|lvl_req);

  // R10: wake must trace back to keyboard or a level-mode request line
  p_wake_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (kbd_irq_o || |(irq_o & ~edge_sel)));
  // R11: an output-direction request pin never shows a level request
  p_out_pin_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    |(lvl_req & dir[NREQ-1:0]) |-> 1'b0);
endmodule

// File: tb/portirq_top_test.sv
module portirq_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = 8'hFF;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] irq_o;
  logic       kbd_irq_o, wake_o;

  typedef struct {
    bit         is_rd;
    logic [7:0] exp;
    string      rq;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  portirq_top uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .kbd_irq_o(kbd_irq_o), .wake_o(wake_o));

  // monitor: compare queued expectations away from the active edge
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_rd ? bus_rdata : {2'b00, wake_o, kbd_irq_o, irq_o};
      vectors++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h (%s)", it.rq, act, it.exp,
                 it.is_rd ? "rdata" : "{wake,kbd,irq}");
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic pins(input logic [7:0] v);
    @(posedge clk); #1;
    pin_i = v;
  endtask

  task automatic exp_out(input logic [3:0] irq, input logic kbd, input logic wk, input string rq);
    item_t it;
    it.is_rd = 1'b0; it.exp = {2'b00, wk, kbd, irq}; it.rq = rq;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [7:0] v, input string rq);
    item_t it;
    bus_addr = a;
    it.is_rd = 1'b1; it.exp = v; it.rq = rq;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    exp_out(4'h0, 1'b0, 1'b0, "R1");
    for (int a = 0; a < 6; a++) exp_rd(3'(a), 8'h00, "R1");

    // R2 / R3 register map
    wr(3'd2, 8'hFF);
    exp_rd(3'd2, 8'h0F, "R2");
    exp_out(4'hF, 1'b0, 1'b1, "R7");
    wr(3'd3, 8'hA5);
    exp_rd(3'd3, 8'hA5, "R3");
    wr(3'd3, 8'h00);
    exp_rd(3'd3, 8'h00, "R3");

    // R7 level mode, active-low polarity; R12 two-edge latency
    wr(3'd1, 8'h0F);
    exp_rd(3'd1, 8'h0F, "R3");
    exp_out(4'h0, 1'b0, 1'b0, "R7");
    pins(8'hFA);
    tick(1);
    exp_out(4'h0, 1'b0, 1'b0, "R12");
    @(posedge clk); #1;
    exp_out(4'h5, 1'b0, 1'b1, "R12");
    wr(3'd2, 8'h01);
    exp_out(4'h1, 1'b0, 1'b1, "R2");

    // R4 keyboard
    wr(3'd3, 8'h30);
    pins(8'hEF);
    tick(2);
    exp_out(4'h0, 1'b1, 1'b1, "R4");
    // R5 other settings do not touch the keyboard path
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h0F);
    exp_out(4'hF, 1'b1, 1'b1, "R5");
    wr(3'd4, 8'h0F);
    exp_out(4'h0, 1'b1, 1'b1, "R5");
    // R6 no software clear
    wr(3'd5, 8'hFF);
    exp_out(4'h0, 1'b1, 1'b1, "R6");
    pins(8'hFF);
    tick(2);
    exp_out(4'h0, 1'b0, 1'b0, "R6");

    // R8 edge mode, rising selected: falling edge ignored
    pins(8'hFE);
    tick(3);
    exp_out(4'h0, 1'b0, 1'b0, "R8");
    pins(8'hFF);
    tick(2);
    exp_out(4'h0, 1'b0, 1'b0, "R8");
    tick(1);
    exp_out(4'h1, 1'b0, 1'b0, "R10");
    exp_rd(3'd5, 8'h01, "R8");
    pins(8'hFE);
    tick(3);
    exp_out(4'h1, 1'b0, 1'b0, "R8");
    // R9 clear by writing one
    wr(3'd5, 8'h00);
    exp_out(4'h1, 1'b0, 1'b0, "R9");
    wr(3'd5, 8'h01);
    exp_out(4'h0, 1'b0, 1'b0, "R9");
    exp_rd(3'd5, 8'h00, "R9");
    // falling edge on pin 1 with polarity 1
    wr(3'd1, 8'h02);
    pins(8'hFC);
    tick(3);
    exp_out(4'h2, 1'b0, 1'b0, "R8");
    wr(3'd2, 8'h01);
    exp_out(4'h0, 1'b0, 1'b0, "R2");
    exp_rd(3'd5, 8'h02, "R8");
    wr(3'd5, 8'h0F);
    exp_rd(3'd5, 8'h00, "R9");

    // R11 direction
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h0F);
    pins(8'hFF);
    tick(2);
    exp_out(4'hF, 1'b0, 1'b1, "R7");
    wr(3'd0, 8'h03);
    exp_rd(3'd0, 8'h03, "R3");
    exp_out(4'hC, 1'b0, 1'b1, "R11");
    wr(3'd3, 8'h02);
    pins(8'hFD);
    tick(2);
    exp_out(4'hC, 1'b0, 1'b1, "R11");
    wr(3'd0, 8'h00);
    exp_out(4'hD, 1'b1, 1'b1, "R4");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule